// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single read and write transactions on a two-wire station management bus (MDC clock, bidirectional MDIO data) in the Clause 22 frame format. A one-cycle `start` pulse launches a transaction. It carries a read/write select, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block returns read data and an error flag together with a one-cycle `done` pulse. The MDIO pad is handled outside the block: the block provides an output value, an output enable and a sampled input.

Every bit occupies one slot. In a slot MDC is low for a fixed number of system clocks and then high for a fixed number of system clocks. A slot in which the block drives MDIO keeps MDC high for one half period. A slot in which the block listens keeps MDC high for a longer read window, so the PHY has time to present data. Both lengths are derived from the system clock frequency and nanosecond parameters.

A transaction moves through these states. IDLE goes to PREAMBLE on an accepted start. PREAMBLE goes to HEADER after 32 slots. In HEADER a write goes to TAIL after 32 slots, and a read goes to RD_TA after 14 slots. RD_TA goes to RD_DATA when the turnaround bit is 0 and to FLUSH when it is 1. RD_DATA goes to TAIL after 16 slots. FLUSH goes to DONE after 32 slots. TAIL goes to DONE after 1 slot. DONE goes back to IDLE after one cycle.

Top module: `mdio_frame_master`

## Requirements
- R1: After synchronous reset the block is idle: `mdc`, `mdio_oe`, `busy`, `done` and `err` are 0 and `rdata` is 0x0000.
- R2: Each slot holds MDC low for HALF cycles and then high. A driven slot stays high for HALF cycles and an input slot for RDHI cycles. `mdio_o` and `mdio_oe` change only at the start of a slot. MDC is low whenever the block is not busy.
- R3: Each frame begins with 32 driven slots carrying logic 1.
- R4: After the preamble the block drives 0,1 and then the opcode: 1,0 for a read, 0,1 for a write. It then drives the PHY address and after that the register address, both MSB first.
- R5: A write keeps driving the turnaround as 1,0, then the 16 data bits MSB first. It then releases MDIO (`mdio_oe`=0) for one input slot before `done`.
- R6: A read releases MDIO right after the register address. Every input slot uses the RDHI high time, and `mdio_i` is sampled on the edge at which MDC falls.
- R7: On a read whose first input bit (turnaround) is 0, the next 16 input bits form `rdata` MSB first, and one further input slot is clocked before `done`. `err` is 0.
- R8: On a read whose turnaround bit is 1, the block clocks 32 more input slots and ignores their values. It then pulses `done` with `rdata`=0xFFFF and `err`=1.
- R9: `done` is a one-cycle pulse in the cycle after the last slot ends. `busy` is high from the cycle after the accepted start through the `done` cycle.
- R10: A `start` seen while `busy` is high has no effect on the frame in progress or on the result.
- R11: HALF = ceil(250 ns × f) and RDHI = ceil(350 ns × f) cycles, where f is the system clock frequency. At 100 MHz these are 25 and 35 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only when idle |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read result, valid with `done` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Turnaround failure flag, valid with `done` |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input sample |

## Verification
A wrong state or an off-by-one slot counter shows up at the pins within one slot. The MDC edge lands a cycle early or late, or `mdio_oe` drops one slot too soon or too late, and a cycle-accurate comparison flags that cycle directly. A mis-latched read/write select or a missed turnaround decision appears within a single slot as the wrong opcode bit or the wrong release point. A shifter fault corrupts the header bit in the slot where it is driven, or shows in `rdata` at the `done` pulse.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_RD_TA,
        ST_RD_DATA,
        ST_FLUSH,
        ST_TAIL,
        ST_DONE
    } mdio_state_t;

    localparam int ADDR_W      = 5;
    localparam int DATA_W      = 16;
    localparam int WR_HDR_BITS = 32;
    localparam int RD_HDR_BITS = 14;

    // Ceiling of ns * kHz / 1e6, at least 1.
    function automatic int ns_to_cycles(input longint clk_khz, input longint ns);
        longint c;
        c = (clk_khz * ns + 64'd999_999) / 64'd1_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/mdio_mdc_timer.sv
module mdio_mdc_timer #(
    parameter int LOW_CYC     = 25,
    parameter int HIGH_TX_CYC = 25,
    parameter int HIGH_RX_CYC = 35
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic slow,
    output logic mdc,
    output logic slot_end
);
    localparam int MAX_A   = (LOW_CYC > HIGH_TX_CYC) ? LOW_CYC : HIGH_TX_CYC;
    localparam int MAX_CYC = (MAX_A > HIGH_RX_CYC) ? MAX_A : HIGH_RX_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt;
    logic          hi;
    logic [CW-1:0] hi_last;

    assign hi_last  = slow ? CW'(HIGH_RX_CYC - 1) : CW'(HIGH_TX_CYC - 1);
    assign slot_end = run && hi && (cnt == hi_last);
    assign mdc      = hi;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hi  <= 1'b0;
            cnt <= '0;
        end else if (!hi) begin
            if (cnt == CW'(LOW_CYC - 1)) begin
                hi  <= 1'b1;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (cnt == hi_last) begin
                hi  <= 1'b0;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter #(
    parameter int TX_W = 32,
    parameter int RX_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [TX_W-1:0] load_word,
    input  logic            tx_shift,
    output logic            tx_bit,
    input  logic            rx_shift,
    input  logic            rx_in,
    output logic [RX_W-1:0] rx_word
);
    logic [TX_W-1:0] tx_q;

    assign tx_bit = tx_q[TX_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_word;
        end else if (tx_shift) begin
            tx_q <= {tx_q[TX_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word <= '0;
        end else if (rx_shift) begin
            rx_word <= {rx_word[RX_W-2:0], rx_in};
        end
    end
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int MDC_HALF_NS = 250,
    parameter int RX_HIGH_NS  = 350,
    parameter int PRE_BITS    = 32,
    parameter int FLUSH_BITS  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              err,
    output logic              busy,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam longint CLK_KHZ  = longint'(CLK_HZ) / 1000;
    localparam int     HALF_CYC = ns_to_cycles(CLK_KHZ, longint'(MDC_HALF_NS));
    localparam int     RDHI_CYC = ns_to_cycles(CLK_KHZ, longint'(RX_HIGH_NS));
    localparam int     MAX_A    = (PRE_BITS > FLUSH_BITS) ? PRE_BITS : FLUSH_BITS;
    localparam int     MAX_BITS = (MAX_A > WR_HDR_BITS) ? MAX_A : WR_HDR_BITS;
    localparam int     CNT_W    = $clog2(MAX_BITS + 1);

    mdio_state_t      state, nstate;
    logic [CNT_W-1:0] bit_cnt;
    logic             is_read;
    logic             slot_end;
    logic             run, slow;
    logic             tx_bit;
    logic [DATA_W-1:0] rx_word;
    logic [WR_HDR_BITS-1:0] hdr_word;
    logic             accept;

    assign accept = (state == ST_IDLE) && start;

    // Frame bits in send order: start, opcode, PHY, register, turnaround, data.
    assign hdr_word = {2'b01, (rd_nwr ? 2'b10 : 2'b01), phy_addr, reg_addr, 2'b10, wdata};

    mdio_mdc_timer #(
        .LOW_CYC    (HALF_CYC),
        .HIGH_TX_CYC(HALF_CYC),
        .HIGH_RX_CYC(RDHI_CYC)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .slow    (slow),
        .mdc     (mdc),
        .slot_end(slot_end)
    );

    mdio_frame_shifter #(
        .TX_W(WR_HDR_BITS),
        .RX_W(DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_word(hdr_word),
        .tx_shift (slot_end && (state == ST_HEADER)),
        .tx_bit   (tx_bit),
        .rx_shift (slot_end && (state == ST_RD_DATA)),
        .rx_in    (mdio_i),
        .rx_word  (rx_word)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state <= nstate;
            if (nstate != state) begin
                bit_cnt <= '0;
            end else if (slot_end) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:     if (start) nstate = ST_PREAMBLE;
            ST_PREAMBLE: if (slot_end && bit_cnt == CNT_W'(PRE_BITS - 1)) nstate = ST_HEADER;
            ST_HEADER: begin
                if (is_read) begin
                    if (slot_end && bit_cnt == CNT_W'(RD_HDR_BITS - 1)) nstate = ST_RD_TA;
                end else begin
                    if (slot_end && bit_cnt == CNT_W'(WR_HDR_BITS - 1)) nstate = ST_TAIL;
                end
            end
            ST_RD_TA:    if (slot_end) nstate = mdio_i ? ST_FLUSH : ST_RD_DATA;
            ST_RD_DATA:  if (slot_end && bit_cnt == CNT_W'(DATA_W - 1)) nstate = ST_TAIL;
            ST_FLUSH:    if (slot_end && bit_cnt == CNT_W'(FLUSH_BITS - 1)) nstate = ST_DONE;
            ST_TAIL:     if (slot_end) nstate = ST_DONE;
            ST_DONE:     nstate = ST_IDLE;
            default:     nstate = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mdio_oe = 1'b0;
        mdio_o  = 1'b0;
        slow    = 1'b0;
        run     = 1'b1;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                run  = 1'b0;
                busy = 1'b0;
            end
            ST_PREAMBLE: begin
                mdio_oe = 1'b1;
                mdio_o  = 1'b1;
            end
            ST_HEADER: begin
                mdio_oe = 1'b1;
                mdio_o  = tx_bit;
            end
            ST_RD_TA, ST_RD_DATA, ST_FLUSH, ST_TAIL: slow = 1'b1;
            ST_DONE: begin
                run  = 1'b0;
                done = 1'b1;
            end
            default: begin
                run  = 1'b0;
                busy = 1'b0;
            end
        endcase
    end

    // Result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            is_read <= 1'b0;
            err     <= 1'b0;
            rdata   <= '0;
        end else begin
            if (accept) begin
                is_read <= rd_nwr;
                err     <= 1'b0;
            end
            if (slot_end && state == ST_RD_TA && mdio_i) begin
                err   <= 1'b1;
                rdata <= '1;
            end
            if (slot_end && state == ST_TAIL && is_read) begin
                rdata <= rx_word;
            end
        end
    end
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk (
    input logic clk,
    input logic rst,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic busy,
    input logic done
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !mdc && !mdio_oe && !done));

    // R2
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !mdc);

    // R2
    drive_stable_high_chk: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_oe) && $stable(mdio_o)));

    // R6
    release_while_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mdio_oe) |-> !mdc);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R9
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> busy);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst) (busy && !done) |=> busy);
endmodule

bind mdio_frame_master mdio_frame_master_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .mdc    (mdc),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe),
    .busy   (busy),
    .done   (done)
);

// File: tb/mdio_frame_master_bench.sv
`timescale 1ns/1ps
module mdio_frame_master_bench;
    localparam int HALF = 25;
    localparam int RDHI = 35;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        done, err, busy, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #5 clk = ~clk;

    mdio_frame_master u_mdio_frame_master (
        .clk(clk), .rst(rst), .start(start), .rd_nwr(rd_nwr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .rdata(rdata), .done(done), .err(err), .busy(busy),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    // PHY-side behaviour requested for the next transaction
    logic [15:0] req_rdval = '0;
    bit          req_ta_bad = 0;
    bit          req_ignore = 0;

    // Reference model: one entry per slot
    bit    q_drv[$];
    bit    q_val[$];
    int    q_hi[$];
    bit    q_phy[$];
    string q_tag[$];

    bit          m_active = 0;
    bit          m_done = 0;
    int          m_idx = 0;
    int          m_c = 0;
    bit          m_read = 0;
    bit          m_ta_bad = 0;
    logic [15:0] m_rdval = '0;
    logic [15:0] m_rdata = '0;
    bit          m_err = 0;
    string       m_done_tag = "R9";

    task automatic push_slot(input bit drv, input bit val, input bit phy, input string tag);
        q_drv.push_back(drv);
        q_val.push_back(val);
        q_hi.push_back(drv ? HALF : RDHI);
        q_phy.push_back(phy);
        q_tag.push_back(tag);
    endtask

    task automatic build_frame();
        q_drv.delete(); q_val.delete(); q_hi.delete(); q_phy.delete(); q_tag.delete();
        for (int i = 0; i < 32; i++) push_slot(1, 1, 1, "R3");
        push_slot(1, 0, 1, "R4");
        push_slot(1, 1, 1, "R4");
        push_slot(1, rd_nwr, 1, "R4");
        push_slot(1, !rd_nwr, 1, "R4");
        for (int i = 4; i >= 0; i--) push_slot(1, phy_addr[i], 1, "R4");
        for (int i = 4; i >= 0; i--) push_slot(1, reg_addr[i], 1, "R4");
        if (!rd_nwr) begin
            push_slot(1, 1, 1, "R5");
            push_slot(1, 0, 1, "R5");
            for (int i = 15; i >= 0; i--) push_slot(1, wdata[i], 1, "R5");
            push_slot(0, 0, 1, "R5");
            m_done_tag = "R5";
        end else begin
            push_slot(0, 0, req_ta_bad, "R6");
            if (req_ta_bad) begin
                for (int i = 0; i < 32; i++) push_slot(0, 0, i[0], "R8");
                m_done_tag = "R8";
            end else begin
                for (int i = 15; i >= 0; i--) push_slot(0, 0, req_rdval[i], "R7");
                push_slot(0, 0, 1, "R7");
                m_done_tag = "R7";
            end
        end
        if (req_ignore) m_done_tag = {m_done_tag, " R10"};
        m_read   = rd_nwr;
        m_ta_bad = req_ta_bad;
        m_rdval  = req_rdval;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_active = 0; m_done = 0; m_idx = 0; m_c = 0;
            m_rdata = '0; m_err = 0;
        end else if (m_done) begin
            m_done = 0;
        end else if (m_active) begin
            m_c++;
            if (m_c == HALF + q_hi[m_idx]) begin
                m_c = 0;
                m_idx++;
                if (m_idx == q_drv.size()) begin
                    m_active = 0;
                    m_done = 1;
                    if (m_read) begin
                        m_err   = m_ta_bad;
                        m_rdata = m_ta_bad ? 16'hFFFF : m_rdval;
                    end
                end
            end
        end else if (start) begin
            build_frame();
            m_active = 1; m_idx = 0; m_c = 0; m_err = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            string tag;
            bit eo;
            tag = m_active ? q_tag[m_idx] : "R9";
            eo  = m_active && q_drv[m_idx];
            chk(busy == (m_active || m_done), "R9 busy", busy, m_active || m_done);
            chk(done == m_done, "R9 done", done, m_done);
            chk(mdc == (m_active && m_c >= HALF), {tag, " R2 R11 mdc"}, mdc, m_active && m_c >= HALF);
            chk(mdio_oe == eo, {tag, " oe"}, mdio_oe, eo);
            if (eo) chk(mdio_o == q_val[m_idx], {tag, " data"}, mdio_o, q_val[m_idx]);
            if (m_done) begin
                chk(rdata == m_rdata, {m_done_tag, " rdata"}, rdata, m_rdata);
                chk(err == m_err, {m_done_tag, " err"}, err, m_err);
            end else if (!m_active) begin
                chk(rdata == m_rdata, "R9 idle rdata", rdata, m_rdata);
                chk(err == m_err, "R9 idle err", err, m_err);
            end
            mdio_i <= (m_active && !q_drv[m_idx]) ? q_phy[m_idx] : 1'b1;
        end
    end

    task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] rv,
                           input bit tab, input bit ign);
        @(negedge clk);
        rd_nwr = rd; phy_addr = pa; reg_addr = ra; wdata = wd;
        req_rdval = rv; req_ta_bad = tab; req_ignore = ign;
        start = 1;
        @(negedge clk);
        start = 0;
        if (ign) begin
            // R10: a second request mid-frame with different fields
            repeat (300) @(negedge clk);
            rd_nwr = !rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd;
            start = 1;
            @(negedge clk);
            start = 0;
        end
        while (m_active || m_done) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !mdc && !mdio_oe && !done && !err, "R1 idle outputs",
            {busy, mdc, mdio_oe, done, err}, 0);
        chk(rdata == 16'h0000, "R1 rdata", rdata, 0);

        run_txn(0, 5'h01, 5'h00, 16'hA5C3, 16'h0000, 0, 0);
        run_txn(1, 5'h1F, 5'h1F, 16'h0000, 16'h8001, 0, 0);
        run_txn(1, 5'h03, 5'h05, 16'h0000, 16'h0000, 1, 0);
        run_txn(0, 5'h10, 5'h11, 16'h0000, 16'h0000, 0, 1);
        run_txn(1, 5'h00, 5'h00, 16'h0000, 16'h1234, 0, 0);
        run_txn(1, 5'h0A, 5'h15, 16'h0000, 16'hFFFE, 0, 1);
        run_txn(0, 5'h15, 5'h0A, 16'hFFFF, 16'h0000, 0, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule